// File: doc/BRIEF.md
# Mailbox Doorbell Console Endpoint

This block is the local end of a byte-wide console that travels through a shared register window: one 32-bit mailbox carries bytes from the remote host to this side, a second carries bytes the other way, and two doorbell registers carry short message codes in each direction. The endpoint is the only master on a simple request/acknowledge register bus toward that window. It reacts to a level doorbell interrupt, reads the incoming code and runs the matching service sequence. Every sequence ends by acknowledging the doorbell.

Received bytes land in a ring buffer that local logic drains through a ready/valid consumer port. Flow control needs no extra signalling. The remote host may only send again once the receive mailbox reads zero, so the endpoint stops zeroing that mailbox when the ring is close to full. It zeroes it again once the consumer has drained enough entries. Local logic hands characters to a ready/valid producer port. The endpoint moves them one at a time into the outgoing mailbox, waits for the remote host to empty it, and rings the remote doorbell after each one.

Top module: `mbc_console_endpoint`

## Requirements
- R1: After reset `rx_valid`, `bus_req`, `connected` and `proto_err` are 0 and `tx_ready` is 1.
- R2: An incoming doorbell code of 1 (keep-alive) is answered by writing 1 to the outgoing doorbell, register index 2.
- R3: An incoming code of 2 (connect) empties the ring, drops any backpressure, writes 0 to the receive mailbox (index 0) and raises `connected`.
- R4: An incoming code of 5 (data) reads the receive mailbox and appends its bits 7:0 to the ring. The consumer sees the bytes in arrival order across the wrap at DEPTH, and `rx_valid` is high exactly while the ring holds data.
- R5: After a byte is stored, the receive mailbox is written to 0 if the ring holds at most DEPTH-MARGIN bytes. Above that the mailbox is left holding its value.
- R6: While backpressure is active, the pop that brings the occupancy below DEPTH-MARGIN releases it and writes 0 to the receive mailbox.
- R7: Each serviced doorbell, whatever its code, is acknowledged by writing all ones to the incoming doorbell register (index 3).
- R8: A producer character is written to the outgoing mailbox (index 1) with bit 31 set, only after that mailbox reads 0, and is followed by code 5 written to the outgoing doorbell. `tx_ready` is low from acceptance until this completes.
- R9: A transmitted 0x0A is followed by a transmitted 0x0D before the producer is accepted again.
- R10: A `disc_req` pulse writes code 3 to the outgoing doorbell and drops `connected`.
- R11: An incoming code outside {1,2,3,5} leaves the ring and outgoing doorbell untouched and sets the sticky `proto_err`.
- R12: An incoming code of 3 (remote disconnect) drops `connected`.
- R13: Once raised, `bus_req` and its address, direction and write data stay stable until the cycle `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_irq | input | 1 | Level: incoming doorbell holds a code |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 2 | 0 rx mailbox, 1 tx mailbox, 2 outgoing doorbell, 3 incoming doorbell |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Access complete this cycle |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| rx_valid | output | 1 | Ring holds a byte |
| rx_data | output | CHAR_W | Oldest byte in the ring |
| rx_ready | input | 1 | Consumer takes `rx_data` |
| tx_valid | input | 1 | Producer offers a character |
| tx_data | input | CHAR_W | Character to send |
| tx_ready | output | 1 | Endpoint accepts a character |
| disc_req | input | 1 | Pulse: announce local disconnect |
| connected | output | 1 | Session established |
| proto_err | output | 1 | Sticky: unknown doorbell code seen |

## Verification
The receive path is swept byte by byte on a 16-entry ring up to and past the backpressure point, so each occupancy tells apart a mailbox that is zeroed from one that is withheld. The drain is then popped one entry at a time to find the exact release point. A second burst crosses the wrap, which separates correct pointer wrapping from data that merely looks right at low addresses. Each doorbell code, including an unlisted one, is rung on its own, and the effect on the outgoing doorbell log tells the sequences apart. Transmit is tried with an empty mailbox, with a mailbox the remote host is still holding, and with a newline, which separates immediate sends, stalled sends and the automatic carriage return.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

   // Register indices in the shared mailbox/doorbell window
   typedef enum logic [1:0] {
      REG_RXMB  = 2'd0,
      REG_TXMB  = 2'd1,
      REG_DBOUT = 2'd2,
      REG_DBIN  = 2'd3
   } mbc_reg_e;

   // Doorbell message codes
   localparam int MSG_ALIVE      = 1;
   localparam int MSG_CONNECT    = 2;
   localparam int MSG_DISCONNECT = 3;
   localparam int MSG_DATA       = 5;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_DB,
      ST_WR_ALIVE,
      ST_RD_RXMB,
      ST_WR_RXZERO,
      ST_WR_ACK,
      ST_WR_REL,
      ST_WR_DISC,
      ST_RD_TXMB,
      ST_WR_TXMB,
      ST_WR_TXDB
   } mbc_state_e;

endpackage

// File: rtl/mbc_ring.sv
module mbc_ring #(
   parameter int DEPTH  = 256,
   parameter int CHAR_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic                      push,
   input  logic [CHAR_W-1:0]         push_data,
   input  logic                      pop,
   output logic                      rd_valid,
   output logic [CHAR_W-1:0]         rd_data,
   output logic [$clog2(DEPTH+1)-1:0] occ_next
);
   localparam int  PW   = $clog2(DEPTH);
   localparam int  OW   = $clog2(DEPTH+1);
   localparam bit  POW2 = (DEPTH == (1 << PW));

   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("mbc_ring: DEPTH must be at least 4");
      end
   endgenerate

   logic [CHAR_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wp, rp, wp_inc, rp_inc;
   logic [OW-1:0]     cnt;
   logic              pop_eff;

   // Pointer advance: free wrap for powers of two, compare otherwise
   generate
      if (POW2) begin : g_wrap_free
         assign wp_inc = wp + 1'b1;
         assign rp_inc = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_inc = (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
         assign rp_inc = (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign rd_valid = (cnt != '0);
   assign rd_data  = mem[rp];
   assign pop_eff  = pop && rd_valid;

   always_comb begin
      if (clear) occ_next = '0;
      else       occ_next = cnt + OW'(push) - OW'(pop_eff);
   end

   always_ff @(posedge clk) begin
      if (push && !clear) mem[wp] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clear) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push)    wp <= wp_inc;
         if (pop_eff) rp <= rp_inc;
         cnt <= occ_next;
      end
   end

   AST_RING_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop_eff && !clear) |-> (cnt < OW'(DEPTH)));          // R4
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !rd_valid);                                          // R3

endmodule

// File: rtl/mbc_tx_slot.sv
module mbc_tx_slot #(
   parameter int          CHAR_W = 8,
   parameter logic [7:0]  NL     = 8'h0A,
   parameter logic [7:0]  CR     = 8'h0D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_data,
   output logic              in_ready,
   input  logic              done,
   output logic              pend,
   output logic [CHAR_W-1:0] ch
);
   generate
      if (CHAR_W < 8) begin : g_bad_width
         $error("mbc_tx_slot: CHAR_W must be at least 8");
      end
   endgenerate

   logic busy, cr_next;

   assign in_ready = !busy;
   assign pend     = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cr_next <= 1'b0;
         ch      <= '0;
      end else if (!busy) begin
         if (in_valid) begin
            busy    <= 1'b1;
            ch      <= in_data;
            cr_next <= (in_data == CHAR_W'(NL));
         end
      end else if (done) begin
         if (cr_next) begin
            ch      <= CHAR_W'(CR);
            cr_next <= 1'b0;
         end else begin
            busy    <= 1'b0;
         end
      end
   end

   AST_CR_FOLLOWS_NL: assert property (@(posedge clk) disable iff (!rst_n)
      (done && busy && ch == CHAR_W'(NL)) |=> (busy && ch == CHAR_W'(CR)));   // R9
   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && $stable(ch)));                             // R8

endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
   import mbc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CHAR_W = 8,
   parameter int DEPTH  = 256,
   parameter int MARGIN = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       db_irq,
   input  logic                       disc_req,
   output logic                       bus_req,
   output logic                       bus_we,
   output logic [1:0]                 bus_addr,
   output logic [DATA_W-1:0]          bus_wdata,
   input  logic                       bus_ack,
   input  logic [DATA_W-1:0]          bus_rdata,
   output logic                       ring_clear,
   output logic                       ring_push,
   output logic [CHAR_W-1:0]          ring_data,
   input  logic                       ring_pop,
   input  logic [$clog2(DEPTH+1)-1:0] ring_occ_next,
   input  logic                       tx_pend,
   input  logic [CHAR_W-1:0]          tx_ch,
   output logic                       tx_done,
   output logic                       connected,
   output logic                       proto_err
);
   localparam int OW     = $clog2(DEPTH+1);
   localparam int THRESH = DEPTH - MARGIN;
   localparam logic [DATA_W-1:0] C_ALIVE = DATA_W'(MSG_ALIVE);
   localparam logic [DATA_W-1:0] C_CONN  = DATA_W'(MSG_CONNECT);
   localparam logic [DATA_W-1:0] C_DISC  = DATA_W'(MSG_DISCONNECT);
   localparam logic [DATA_W-1:0] C_DATA  = DATA_W'(MSG_DATA);
   localparam logic [DATA_W-1:0] C_TAG   = DATA_W'(1) << (DATA_W-1);

   generate
      if (MARGIN < 1 || MARGIN >= DEPTH) begin : g_bad_margin
         $error("mbc_seq: MARGIN must lie in 1..DEPTH-1");
      end
      if (DATA_W <= CHAR_W) begin : g_bad_data_w
         $error("mbc_seq: DATA_W must exceed CHAR_W to carry the tag bit");
      end
   endgenerate

   mbc_state_e state, nxt;
   logic full_q, rel_pend, disc_pend, conn_q, err_q;
   logic is_conn, is_alive, is_disc, is_data;
   logic over_th, under_th;

   assign is_alive = (bus_rdata == C_ALIVE);
   assign is_conn  = (bus_rdata == C_CONN);
   assign is_disc  = (bus_rdata == C_DISC);
   assign is_data  = (bus_rdata == C_DATA);
   assign over_th  = (ring_occ_next > OW'(THRESH));
   assign under_th = (ring_occ_next < OW'(THRESH));

   assign connected = conn_q;
   assign proto_err = err_q;

   // Next state and bus command, all from the current state
   always_comb begin
      nxt        = state;
      bus_req    = 1'b0;
      bus_we     = 1'b0;
      bus_addr   = REG_RXMB;
      bus_wdata  = '0;
      ring_clear = 1'b0;
      ring_push  = 1'b0;
      ring_data  = bus_rdata[CHAR_W-1:0];
      tx_done    = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (db_irq)         nxt = ST_RD_DB;
            else if (rel_pend)  nxt = ST_WR_REL;
            else if (disc_pend) nxt = ST_WR_DISC;
            else if (tx_pend)   nxt = ST_RD_TXMB;
         end
         ST_RD_DB: begin
            bus_req  = 1'b1;
            bus_addr = REG_DBIN;
            if (bus_ack) begin
               if (is_alive)     nxt = ST_WR_ALIVE;
               else if (is_conn) begin
                  nxt        = ST_WR_RXZERO;
                  ring_clear = 1'b1;
               end
               else if (is_data) nxt = ST_RD_RXMB;
               else              nxt = ST_WR_ACK;
            end
         end
         ST_WR_ALIVE: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = REG_DBOUT;
            bus_wdata = C_ALIVE;
            if (bus_ack) nxt = ST_WR_ACK;
         end
         ST_RD_RXMB: begin
            bus_req  = 1'b1;
            bus_addr = REG_RXMB;
            if (bus_ack) begin
               ring_push = 1'b1;
               nxt = over_th ? ST_WR_ACK : ST_WR_RXZERO;
            end
         end
         ST_WR_RXZERO: begin
            bus_req  = 1'b1;
            bus_we   = 1'b1;
            bus_addr = REG_RXMB;
            if (bus_ack) nxt = ST_WR_ACK;
         end
         ST_WR_ACK: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = REG_DBIN;
            bus_wdata = '1;
            if (bus_ack) nxt = ST_IDLE;
         end
         ST_WR_REL: begin
            bus_req  = 1'b1;
            bus_we   = 1'b1;
            bus_addr = REG_RXMB;
            if (bus_ack) nxt = ST_IDLE;
         end
         ST_WR_DISC: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = REG_DBOUT;
            bus_wdata = C_DISC;
            if (bus_ack) nxt = ST_IDLE;
         end
         ST_RD_TXMB: begin
            bus_req  = 1'b1;
            bus_addr = REG_TXMB;
            if (bus_ack) nxt = (bus_rdata == '0) ? ST_WR_TXMB : ST_IDLE;
         end
         ST_WR_TXMB: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = REG_TXMB;
            bus_wdata = C_TAG | DATA_W'(tx_ch);
            if (bus_ack) nxt = ST_WR_TXDB;
         end
         ST_WR_TXDB: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = REG_DBOUT;
            bus_wdata = C_DATA;
            if (bus_ack) begin
               nxt     = ST_IDLE;
               tx_done = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         full_q    <= 1'b0;
         rel_pend  <= 1'b0;
         disc_pend <= 1'b0;
         conn_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         state <= nxt;

         // Backpressure bookkeeping
         if (ring_clear) begin
            full_q   <= 1'b0;
            rel_pend <= 1'b0;
         end else if (ring_push && over_th) begin
            full_q   <= 1'b1;
         end else if (full_q && ring_pop && under_th) begin
            full_q   <= 1'b0;
            rel_pend <= 1'b1;
         end else if (state == ST_WR_REL && bus_ack) begin
            rel_pend <= 1'b0;
         end

         // Session status
         if (state == ST_RD_DB && bus_ack) begin
            if (is_conn)      conn_q <= 1'b1;
            else if (is_disc) conn_q <= 1'b0;
            if (!(is_alive || is_conn || is_disc || is_data)) err_q <= 1'b1;
         end
         if (state == ST_WR_DISC && bus_ack) conn_q <= 1'b0;

         disc_pend <= disc_req || (disc_pend && !(state == ST_WR_DISC && bus_ack));
      end
   end

   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_wdata)));                        // R13
   AST_ACK_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == REG_DBIN) |-> (bus_wdata == '1));        // R7
   AST_TX_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == REG_TXMB)
         |-> (bus_wdata[DATA_W-1] && bus_wdata[DATA_W-2:CHAR_W] == '0));         // R8
   AST_FULL_HOLDS_MB: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> !(bus_req && bus_we && bus_addr == REG_RXMB));                  // R5
   AST_DISC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR_DISC && bus_ack) |=> !connected);                          // R10

endmodule

// File: rtl/mbc_console_endpoint.sv
module mbc_console_endpoint #(
   parameter int DATA_W = 32,
   parameter int CHAR_W = 8,
   parameter int DEPTH  = 256,
   parameter int MARGIN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              db_irq,
   output logic              bus_req,
   output logic              bus_we,
   output logic [1:0]        bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              rx_valid,
   output logic [CHAR_W-1:0] rx_data,
   input  logic              rx_ready,
   input  logic              tx_valid,
   input  logic [CHAR_W-1:0] tx_data,
   output logic              tx_ready,
   input  logic              disc_req,
   output logic              connected,
   output logic              proto_err
);
   localparam int OW = $clog2(DEPTH+1);

   logic              ring_clear, ring_push, ring_pop;
   logic [CHAR_W-1:0] ring_data;
   logic [OW-1:0]     occ_next;
   logic              tx_pend, tx_done;
   logic [CHAR_W-1:0] tx_ch;

   assign ring_pop = rx_valid && rx_ready;

   mbc_ring #(.DEPTH(DEPTH), .CHAR_W(CHAR_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (ring_clear),
      .push      (ring_push),
      .push_data (ring_data),
      .pop       (ring_pop),
      .rd_valid  (rx_valid),
      .rd_data   (rx_data),
      .occ_next  (occ_next)
   );

   mbc_tx_slot #(.CHAR_W(CHAR_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (tx_valid),
      .in_data  (tx_data),
      .in_ready (tx_ready),
      .done     (tx_done),
      .pend     (tx_pend),
      .ch       (tx_ch)
   );

   mbc_seq #(.DATA_W(DATA_W), .CHAR_W(CHAR_W), .DEPTH(DEPTH), .MARGIN(MARGIN)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .db_irq        (db_irq),
      .disc_req      (disc_req),
      .bus_req       (bus_req),
      .bus_we        (bus_we),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .bus_ack       (bus_ack),
      .bus_rdata     (bus_rdata),
      .ring_clear    (ring_clear),
      .ring_push     (ring_push),
      .ring_data     (ring_data),
      .ring_pop      (ring_pop),
      .ring_occ_next (occ_next),
      .tx_pend       (tx_pend),
      .tx_ch         (tx_ch),
      .tx_done       (tx_done),
      .connected     (connected),
      .proto_err     (proto_err)
   );

   AST_TX_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);                       // R8

endmodule

// File: tb/mbc_console_endpoint_test.sv
module mbc_console_endpoint_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 16;
   localparam int MARGIN = 4;
   localparam int THRESH = DEPTH - MARGIN;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req, bus_we, b_ack;
   logic [1:0]  bus_addr;
   logic [31:0] bus_wdata, b_rdata;
   logic        rx_valid, rx_ready, tx_valid, tx_ready, disc_req, connected, proto_err;
   logic [7:0]  rx_data, tx_data;

   // Remote side model of the mailbox/doorbell window
   logic [31:0] m_rx, m_tx, m_din;
   logic [31:0] dbo_log [64];
   logic [31:0] txm_log [64];
   int          dbo_n, txm_n, hs_bad;
   int          rcmd;
   logic [31:0] rval;
   logic        prev_pend, prev_we;
   logic [1:0]  prev_addr;
   logic [31:0] prev_wd;

   int  n_chk = 0, n_fail = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbc_console_endpoint #(.DATA_W(32), .CHAR_W(8), .DEPTH(DEPTH), .MARGIN(MARGIN)) uut (
      .clk(clk), .rst_n(rst_n), .db_irq(m_din != 32'd0),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(b_ack), .bus_rdata(b_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .disc_req(disc_req), .connected(connected), .proto_err(proto_err)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rx <= 0; m_tx <= 0; m_din <= 0; b_ack <= 0; b_rdata <= 0;
         dbo_n <= 0; txm_n <= 0; hs_bad <= 0; prev_pend <= 0;
         prev_we <= 0; prev_addr <= 0; prev_wd <= 0;
      end else begin
         if (prev_pend && (!bus_req || bus_addr != prev_addr || bus_we != prev_we
                           || bus_wdata != prev_wd))
            hs_bad <= hs_bad + 1;
         prev_pend <= bus_req && !b_ack;
         prev_addr <= bus_addr; prev_we <= bus_we; prev_wd <= bus_wdata;
         b_ack <= 1'b0;
         if (bus_req && !b_ack) begin
            b_ack <= 1'b1;
            if (bus_we) begin
               case (bus_addr)
                  2'd0: m_rx <= bus_wdata;
                  2'd1: begin m_tx <= bus_wdata; txm_log[txm_n[5:0]] <= bus_wdata; txm_n <= txm_n + 1; end
                  2'd2: begin dbo_log[dbo_n[5:0]] <= bus_wdata; dbo_n <= dbo_n + 1; end
                  default: m_din <= m_din & ~bus_wdata;
               endcase
            end else begin
               case (bus_addr)
                  2'd0: b_rdata <= m_rx;
                  2'd1: b_rdata <= m_tx;
                  2'd2: b_rdata <= 32'd0;
                  default: b_rdata <= m_din;
               endcase
            end
         end
         case (rcmd)
            1: begin m_rx <= rval; m_din <= 32'd5; end
            2: m_din <= rval;
            3: m_tx <= 32'd0;
            4: m_rx <= rval;
            default: ;
         endcase
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic settle();
      while (m_din != 32'd0) @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   task automatic remote(input int cmd, input logic [31:0] v);
      @(negedge clk); rcmd = cmd; rval = v;
      @(negedge clk); rcmd = 0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      remote(1, 32'h5A3C_0000 | {24'd0, b});
      settle();
   endtask

   task automatic pop_byte(output logic [7:0] b);
      @(negedge clk); b = rx_data; rx_ready = 1'b1;
      @(negedge clk); rx_ready = 1'b0;
   endtask

   task automatic put_char(input logic [7:0] c);
      @(negedge clk); tx_valid = 1'b1; tx_data = c;
      @(negedge clk); tx_valid = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 5) & 255);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      int d0, t0;
      rcmd = 0; rval = 0; rx_ready = 0; tx_valid = 0; tx_data = 0; disc_req = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 rx_valid", {31'd0, rx_valid}, 0);
      chk("R1 tx_ready", {31'd0, tx_ready}, 1);
      chk("R1 connected", {31'd0, connected}, 0);
      chk("R1 proto_err", {31'd0, proto_err}, 0);
      chk("R1 bus_req", {31'd0, bus_req}, 0);

      // R2 keep-alive reply, R7 acknowledge
      remote(2, 32'd1); settle();
      chk("R2 reply count", dbo_n, 1);
      chk("R2 reply code", dbo_log[0], 32'd1);
      chk("R7 doorbell cleared", m_din, 0);

      // R3 connect zeroes the receive mailbox
      remote(4, 32'hDEAD_BEEF);
      remote(2, 32'd2); settle();
      chk("R3 connected", {31'd0, connected}, 1);
      chk("R3 rx mailbox zeroed", m_rx, 0);

      // R4/R5 fill up to the threshold, mailbox zeroed each time
      for (int i = 0; i < THRESH; i++) begin
         send_byte(pat(i));
         chk("R5 mailbox zeroed below threshold", m_rx, 0);
      end
      chk("R4 rx_valid with data", {31'd0, rx_valid}, 1);
      send_byte(pat(THRESH));
      chk("R5 mailbox held above threshold", m_rx, 32'h5A3C_0000 | {24'd0, pat(THRESH)});

      // R6 release point
      pop_byte(b); chk("R4 order", {24'd0, b}, {24'd0, pat(0)});
      repeat (8) @(negedge clk);
      chk("R6 still held at threshold", (m_rx != 0) ? 32'd1 : 32'd0, 1);
      pop_byte(b); chk("R4 order", {24'd0, b}, {24'd0, pat(1)});
      repeat (8) @(negedge clk);
      chk("R6 released below threshold", m_rx, 0);
      for (int i = 2; i <= THRESH; i++) begin
         pop_byte(b); chk("R4 order", {24'd0, b}, {24'd0, pat(i)});
      end
      chk("R4 empty after drain", {31'd0, rx_valid}, 0);

      // R4 wrap across DEPTH
      for (int i = 0; i < 10; i++) send_byte(pat(100 + i));
      for (int i = 0; i < 10; i++) begin
         pop_byte(b); chk("R4 wrap order", {24'd0, b}, {24'd0, pat(100 + i)});
      end

      // R3 connect empties ring
      for (int i = 0; i < 3; i++) send_byte(pat(200 + i));
      remote(2, 32'd2); settle();
      chk("R3 ring emptied", {31'd0, rx_valid}, 0);

      // R8 transmit with empty mailbox
      d0 = dbo_n; t0 = txm_n;
      put_char(8'h41);
      chk("R8 ready low while pending", {31'd0, tx_ready}, 0);
      repeat (20) @(negedge clk);
      chk("R8 tx write", txm_log[t0[5:0]], 32'h8000_0041);
      chk("R8 tx doorbell", dbo_log[d0[5:0]], 32'd5);
      chk("R8 ready again", {31'd0, tx_ready}, 1);

      // R8 stall while remote holds the mailbox
      t0 = txm_n;
      put_char(8'h42);
      repeat (50) @(negedge clk);
      chk("R8 no write while mailbox busy", txm_n, t0);
      chk("R8 ready low while stalled", {31'd0, tx_ready}, 0);
      remote(3, 0);
      repeat (20) @(negedge clk);
      chk("R8 write after release", txm_log[t0[5:0]], 32'h8000_0042);

      // R9 newline followed by carriage return
      remote(3, 0);
      d0 = dbo_n; t0 = txm_n;
      put_char(8'h0A);
      while (txm_n == t0) @(negedge clk);
      repeat (10) @(negedge clk);
      chk("R9 ready low before CR", {31'd0, tx_ready}, 0);
      remote(3, 0);
      repeat (20) @(negedge clk);
      chk("R9 first char", txm_log[t0[5:0]], 32'h8000_000A);
      chk("R9 second char", txm_log[(t0 + 1) & 63], 32'h8000_000D);
      chk("R9 two doorbells", dbo_n - d0, 2);
      remote(3, 0);

      // R11 unknown code
      send_byte(8'h77);
      d0 = dbo_n;
      remote(2, 32'd7); settle();
      chk("R11 error flag", {31'd0, proto_err}, 1);
      chk("R11 no outgoing doorbell", dbo_n, d0);
      chk("R7 unknown acknowledged", m_din, 0);
      pop_byte(b);
      chk("R11 ring untouched", {24'd0, b, 7'd0, rx_valid}, {24'd0, 8'h77, 8'd0});

      // R12 remote disconnect
      remote(2, 32'd3); settle();
      chk("R12 connected dropped", {31'd0, connected}, 0);
      chk("R11 error sticky", {31'd0, proto_err}, 1);

      // R10 local disconnect
      remote(2, 32'd2); settle();
      d0 = dbo_n;
      @(negedge clk); disc_req = 1'b1;
      @(negedge clk); disc_req = 1'b0;
      repeat (10) @(negedge clk);
      chk("R10 disconnect code", dbo_log[d0[5:0]], 32'd3);
      chk("R10 connected dropped", {31'd0, connected}, 0);

      // R13 handshake stability seen by the bus monitor
      chk("R13 handshake violations", hs_bad, 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule